// File: doc/BRIEF.md
# Chained Four-Channel Down-Counter Timer

The block holds four 16-bit down-counting timer channels that share one prescaler and one pair of start and stop strobes. A channel can run on its own as an interval timer, or it can join a group led by a lower-numbered leader channel. Inside a group, the leader's count enable and its interrupt pulse flow upward to its followers. A follower either counts on the leader's enable as a second interval timer, or waits for each leader interrupt and then runs a single countdown.

The block works out the group structure from the per-channel configuration inputs. It decides which start and stop strobes take effect, and it holds a channel stopped while that channel's configuration breaks a grouping rule. Any such breach also sets a sticky error flag, which only reset clears.

Top module: `chained_timer_array`

## Requirements
- R1: The prescaler gives four enables. Enable k pulses once every 2^(k*CK_SHIFT) cycles: with the default CK_SHIFT = 1, once every 1, 2, 4 and 8 cycles. It starts on the first cycle after reset with enable 0 high. A running channel steps only on the enable it follows.
- R2: Mode 0 (standalone) loads `cfg_data` when a start takes effect and moves one step down on each enable it follows. At zero it reloads instead of stepping, and `irq` goes high for exactly the next cycle. The interrupt period is therefore data+1 enables.
- R3: Channel 0 always leads a group, and its bit in `cfg_master` has no effect. Channel 0 in mode 1 or 2 is a configuration error.
- R4: A `cfg_master` bit set on an odd channel (1 or 3) is a configuration error.
- R5: A follower (mode 1 or 2 on a channel that does not lead) belongs to the closest lower channel that leads. Channel 2 leads when its `cfg_master` bit is set. Channel 3 therefore follows channel 2 when that bit is set, and otherwise follows channel 0.
- R6: Mode 1 (triggered follower) does not count after its start. On each interrupt pulse from its leader it loads `cfg_data` and counts on the leader's enable. At zero it pulses `irq` once and waits for the next leader interrupt.
- R7: Mode 2 (clock follower) behaves as in R2, but it counts on the leader's selected enable.
- R8: A follower's 2-bit clock field (channel n at `cfg_cks[2n+1:2n]`) must equal its leader's field, and the leader's field must be 0 or 1. A breach is a configuration error.
- R9: Start bits set in the same cycle start those channels in that cycle. Stop bits set in the same cycle stop them together. `run_status` bit n is 1 while channel n is enabled.
- R10: While a follower's leader is running, a start on that follower is ignored unless the leader's start bit is set in the same cycle. While the leader is stopped, a start on the follower alone is accepted. A start on a leader alone is always accepted.
- R11: Mode 3 is reserved and is a configuration error. `cfg_err` rises in the cycle after any error condition is present and stays at 1 until reset, even after the configuration is corrected.
- R12: A channel with a configuration error is stopped one cycle later and ignores starts. A stop bit takes priority over a start bit set in the same cycle. `irq` is only ever high on a running channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 4 | Leader request bit per channel (bit 0 has no effect) |
| cfg_cks | input | 8 | Clock select per channel, channel n at [2n+1:2n] |
| cfg_mode | input | 8 | Mode per channel, channel n at [2n+1:2n]: 0 standalone, 1 triggered follower, 2 clock follower, 3 reserved |
| cfg_data | input | 64 | Reload value per channel, channel n at [16n+15:16n] |
| start_req | input | 4 | One-cycle start strobes |
| stop_req | input | 4 | One-cycle stop strobes |
| run_status | output | 4 | Channel enabled flags |
| irq | output | 4 | One-cycle interrupt pulse per channel |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The hardest states to reach are those that depend on timing relative to a running group. One is a follower start that arrives while the leader is counting. Another is a clock-select mismatch introduced into a group that is already running, after which the flag must stay set once the mismatch is repaired. The stimulus first builds and starts a full group. It then stops one follower alone, retries that follower by itself, and retries it again together with the leader. In a second grouping led by channel 2, it changes one follower's clock field while the group runs, waits, restores the field, and restarts. A behavioural model checks every cycle, and counted interrupt totals over fixed windows confirm the periods.

// File: rtl/cta_pkg.sv
`timescale 1ns/1ps
package cta_pkg;

  typedef enum logic [1:0] {
    MD_SOLO   = 2'd0,
    MD_TRIG   = 2'd1,
    MD_FOLLOW = 2'd2,
    MD_RSVD   = 2'd3
  } cta_mode_e;

  localparam int NUM_CK = 4;

  // A channel may lead a group: channel 0 always, other even channels on request.
  function automatic logic may_lead(input int idx, input logic req);
    if (idx == 0) return 1'b1;
    return ((idx % 2) == 0) && req;
  endfunction

  // Closest lower leading channel below idx.
  function automatic int owner_of(input logic [31:0] leads, input int idx);
    int pick;
    pick = 0;
    for (int m = 0; m < 32; m++)
      if (m < idx && leads[m]) pick = m;
    return pick;
  endfunction

  // Low-bit mask of the prescaler counter for enable k.
  function automatic int pre_mask(input int k, input int shift);
    return (1 << (k * shift)) - 1;
  endfunction

endpackage

// File: rtl/cta_presc.sv
`timescale 1ns/1ps
module cta_presc import cta_pkg::*; #(
  parameter int CK_SHIFT = 1,
  localparam int PW = (NUM_CK - 1) * CK_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [NUM_CK-1:0] ck_en
);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt + PW'(1);
  end

  for (genvar k = 0; k < NUM_CK; k++) begin : g_en
    localparam logic [PW-1:0] MSK = PW'(pre_mask(k, CK_SHIFT));
    assign ck_en[k] = (pcnt & MSK) == MSK;
    if (k > 0) begin : g_chk
      assert_en_spaced_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ck_en[k] |=> !ck_en[k]);
    end
  end

endmodule

// File: rtl/cta_group.sv
`timescale 1ns/1ps
module cta_group import cta_pkg::*; #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cfg_master,
  input  logic [2*NCH-1:0]  cfg_cks,
  input  logic [2*NCH-1:0]  cfg_mode,
  input  logic [NCH-1:0]    start_req,
  input  logic [NCH-1:0]    stop_req,
  input  logic [NCH-1:0]    irq_all,
  input  logic [NUM_CK-1:0] ck_en,
  output logic [NCH-1:0]    run,
  output logic [NCH-1:0]    run_nxt,
  output logic [NCH-1:0]    start_acc,
  output logic [NCH-1:0]    slave_trig,
  output logic [NCH-1:0]    tick,
  output logic [NCH-1:0]    trig_in,
  output logic              cfg_err
);

  logic [NCH-1:0] is_lead;
  logic [NCH-1:0] is_slave;
  logic [NCH-1:0] bad;
  logic [IW-1:0]  own [NCH];

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    cta_mode_e  md;
    logic [1:0] ck_own;
    logic [1:0] ck_lead;

    assign md         = cta_mode_e'(cfg_mode[2*n +: 2]);
    assign ck_own     = cfg_cks[2*n +: 2];
    assign is_lead[n] = may_lead(n, cfg_master[n]);
    assign own[n]     = IW'(owner_of(32'(is_lead), n));
    assign ck_lead    = cfg_cks[2*own[n] +: 2];
    assign is_slave[n] = (md == MD_TRIG || md == MD_FOLLOW) && !is_lead[n];

    assign bad[n] = (md == MD_RSVD)
                 || (((n % 2) == 1) && cfg_master[n])
                 || (is_lead[n] && md != MD_SOLO)
                 || (is_slave[n] && (ck_own != ck_lead || ck_lead[1]));

    assign slave_trig[n] = is_slave[n] && (md == MD_TRIG);
    assign tick[n]       = is_slave[n] ? ck_en[ck_lead] : ck_en[ck_own];
    assign trig_in[n]    = is_slave[n] && irq_all[own[n]];

    assign start_acc[n] = start_req[n] && !bad[n]
                       && (!is_slave[n] || !run[own[n]] || start_req[own[n]]);
    assign run_nxt[n]   = !bad[n] && !stop_req[n] && (start_acc[n] || run[n]);

    assert_slave_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_slave[n] && run[own[n]] && start_req[n] && !start_req[own[n]] && !run[n])
        |=> !run[n]);
    assert_stop_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req[n] |=> !run[n]);
    assert_bad_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bad[n] |=> !run[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= '0;
      cfg_err <= 1'b0;
    end else begin
      run     <= run_nxt;
      cfg_err <= cfg_err | (|bad);
    end
  end

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

// File: rtl/cta_channel.sv
`timescale 1ns/1ps
module cta_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_nxt,
  input  logic          start_acc,
  input  logic          slave_trig,
  input  logic          tick,
  input  logic          trig_in,
  input  logic [CW-1:0] data,
  output logic          irq
);

  logic [CW-1:0] cnt;
  logic          active;
  logic          retrig;
  logic          step;
  logic          zero_hit;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] cur,
                                              input logic [CW-1:0] rld);
    return (cur == '0) ? rld : cur - CW'(1);
  endfunction

  assign retrig   = run_nxt && !start_acc && slave_trig && trig_in;
  assign step     = run_nxt && !start_acc && !retrig && active && tick;
  assign zero_hit = step && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= zero_hit;
      if (!run_nxt) begin
        active <= 1'b0;
      end else if (start_acc) begin
        cnt    <= data;
        active <= !slave_trig;
      end else if (retrig) begin
        cnt    <= data;
        active <= 1'b1;
      end else if (step) begin
        cnt <= step_down(cnt, data);
        if (zero_hit && slave_trig) active <= 1'b0;
      end
    end
  end

  assert_irq_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));
  assert_trig_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active) && $past(slave_trig)) |-> $past(trig_in));

endmodule

// File: rtl/chained_timer_array.sv
`timescale 1ns/1ps
module chained_timer_array import cta_pkg::*; #(
  parameter int NCH      = 4,
  parameter int CW       = 16,
  parameter int CK_SHIFT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cfg_master,
  input  logic [2*NCH-1:0]  cfg_cks,
  input  logic [2*NCH-1:0]  cfg_mode,
  input  logic [CW*NCH-1:0] cfg_data,
  input  logic [NCH-1:0]    start_req,
  input  logic [NCH-1:0]    stop_req,
  output logic [NCH-1:0]    run_status,
  output logic [NCH-1:0]    irq,
  output logic              cfg_err
);

  logic [NUM_CK-1:0] ck_en;
  logic [NCH-1:0]    run_nxt;
  logic [NCH-1:0]    start_acc;
  logic [NCH-1:0]    slave_trig;
  logic [NCH-1:0]    tick;
  logic [NCH-1:0]    trig_in;

  cta_presc #(.CK_SHIFT(CK_SHIFT)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .ck_en (ck_en)
  );

  cta_group #(.NCH(NCH)) u_group (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_master (cfg_master),
    .cfg_cks    (cfg_cks),
    .cfg_mode   (cfg_mode),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .irq_all    (irq),
    .ck_en      (ck_en),
    .run        (run_status),
    .run_nxt    (run_nxt),
    .start_acc  (start_acc),
    .slave_trig (slave_trig),
    .tick       (tick),
    .trig_in    (trig_in),
    .cfg_err    (cfg_err)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    cta_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_nxt    (run_nxt[n]),
      .start_acc  (start_acc[n]),
      .slave_trig (slave_trig[n]),
      .tick       (tick[n]),
      .trig_in    (trig_in[n]),
      .data       (cfg_data[CW*n +: CW]),
      .irq        (irq[n])
    );
  end

  assert_irq_needs_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~run_status) == '0);

endmodule

// File: tb/chained_timer_array_bench.sv
`timescale 1ns/1ps
module chained_timer_array_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_master = '0;
  logic [7:0]  cfg_cks = '0;
  logic [7:0]  cfg_mode = '0;
  logic [63:0] cfg_data = '0;
  logic [3:0]  start_req = '0;
  logic [3:0]  stop_req = '0;
  logic [3:0]  run_status;
  logic [3:0]  irq;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chained_timer_array u_chained_timer_array (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cks(cfg_cks),
    .cfg_mode(cfg_mode), .cfg_data(cfg_data), .start_req(start_req),
    .stop_req(stop_req), .run_status(run_status), .irq(irq), .cfg_err(cfg_err)
  );

  // Behavioural reference model
  int m_pre;
  int m_cnt [4];
  bit m_run [4];
  bit m_act [4];
  bit m_irq [4];
  bit m_err;

  function automatic int field2(input logic [7:0] v, input int n);
    return int'(v[2*n +: 2]);
  endfunction

  task automatic model_step();
    bit en [4];
    bit lead [4];
    int boss [4];
    bit slv [4];
    bit bad [4];
    bit acc [4];
    bit nxt [4];
    bit old_irq [4];
    int md, ck, bck, dat;
    for (int k = 0; k < 4; k++) en[k] = (m_pre % (1 << k)) == ((1 << k) - 1);
    m_pre++;
    lead[0] = 1; lead[1] = 0; lead[2] = cfg_master[2]; lead[3] = 0;
    boss[0] = 0; boss[1] = 0; boss[2] = 0; boss[3] = lead[2] ? 2 : 0;
    for (int n = 0; n < 4; n++) begin
      md  = field2(cfg_mode, n);
      ck  = field2(cfg_cks, n);
      bck = field2(cfg_cks, boss[n]);
      slv[n] = (md == 1 || md == 2) && !lead[n];
      bad[n] = (md == 3) || ((n % 2) == 1 && cfg_master[n]) || (lead[n] && md != 0)
            || (slv[n] && (ck != bck || bck >= 2));
      if (bad[n]) m_err = 1;
    end
    for (int n = 0; n < 4; n++) begin
      acc[n] = start_req[n] && !bad[n] &&
               (!slv[n] || !m_run[boss[n]] || start_req[boss[n]]);
      nxt[n] = !bad[n] && !stop_req[n] && (acc[n] || m_run[n]);
      old_irq[n] = m_irq[n];
    end
    for (int n = 0; n < 4; n++) begin
      bit trg, tk;
      md  = field2(cfg_mode, n);
      dat = int'(cfg_data[16*n +: 16]);
      trg = slv[n] && md == 1;
      tk  = slv[n] ? en[field2(cfg_cks, boss[n])] : en[field2(cfg_cks, n)];
      m_irq[n] = 0;
      if (!nxt[n]) m_act[n] = 0;
      else if (acc[n]) begin m_cnt[n] = dat; m_act[n] = !trg; end
      else if (trg && old_irq[boss[n]]) begin m_cnt[n] = dat; m_act[n] = 1; end
      else if (m_act[n] && tk) begin
        if (m_cnt[n] == 0) begin
          m_irq[n] = 1;
          m_cnt[n] = dat;
          if (trg) m_act[n] = 0;
        end else m_cnt[n] = m_cnt[n] - 1;
      end
      m_run[n] = nxt[n];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0;
      m_err = 0;
      for (int n = 0; n < 4; n++) begin
        m_cnt[n] = 0; m_run[n] = 0; m_act[n] = 0; m_irq[n] = 0;
      end
    end else model_step();
  end

  function automatic logic [3:0] pack4(input bit v [4]);
    return {v[3], v[2], v[1], v[0]};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks += 3;
      if (run_status !== pack4(m_run)) begin
        errors++;
        $display("FAIL R9/R10/R12 run_status actual %b expected %b at %0t",
                 run_status, pack4(m_run), $time);
      end
      if (irq !== pack4(m_irq)) begin
        errors++;
        $display("FAIL R1/R2/R5/R6/R7 irq actual %b expected %b at %0t",
                 irq, pack4(m_irq), $time);
      end
      if (cfg_err !== m_err) begin
        errors++;
        $display("FAIL R3/R4/R8/R11 cfg_err actual %b expected %b at %0t",
                 cfg_err, m_err, $time);
      end
    end
  end

  // Directed checks
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(input int n, input bit mst, input int ck, input int md,
                        input int dat);
    cfg_master[n] = mst;
    cfg_cks[2*n +: 2] = 2'(ck);
    cfg_mode[2*n +: 2] = 2'(md);
    cfg_data[16*n +: 16] = 16'(dat);
  endtask

  task automatic pulse(input logic [3:0] st, input logic [3:0] sp);
    @(negedge clk);
    start_req = st; stop_req = sp;
    @(negedge clk);
    start_req = '0; stop_req = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_master = '0; cfg_cks = '0; cfg_mode = '0; cfg_data = '0;
    start_req = '0; stop_req = '0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  task automatic count_irq(input int ch, input int ncyc, output int c);
    c = 0;
    repeat (ncyc) begin
      @(negedge clk);
      if (irq[ch]) c++;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int c;
    do_reset();
    @(negedge clk);
    chk("R11 reset cfg_err", int'(cfg_err), 0);
    chk("R9 reset run_status", int'(run_status), 0);
    chk("R2 reset irq", int'(irq), 0);

    // Standalone channels on different enables
    set_ch(0, 0, 0, 0, 3);
    set_ch(1, 0, 1, 0, 2);
    set_ch(2, 0, 2, 0, 1);
    set_ch(3, 0, 3, 0, 0);
    pulse(4'hF, 4'h0);
    chk("R9 group start", int'(run_status), 15);
    cyc(30);
    count_irq(0, 40, c);
    chk("R2 ch0 period 4", c, 10);
    count_irq(3, 40, c);
    chk("R1 ch3 on enable 3", c, 5);
    pulse(4'h0, 4'hF);
    chk("R9 group stop", int'(run_status), 0);

    // Group led by channel 0
    set_ch(0, 0, 1, 0, 4);
    set_ch(1, 0, 1, 1, 1);
    set_ch(2, 0, 1, 2, 2);
    set_ch(3, 0, 1, 2, 0);
    pulse(4'hF, 4'h0);
    chk("R9 chained start", int'(run_status), 15);
    chk("R8 matched clocks", int'(cfg_err), 0);
    cyc(60);
    count_irq(3, 40, c);
    chk("R7 follower on leader enable", c, 20);
    count_irq(1, 40, c);
    chk("R6 one shot per leader irq", c, 4);

    pulse(4'h0, 4'b0100);
    chk("R9 single stop", int'(run_status), 11);
    pulse(4'b0100, 4'h0);
    chk("R10 follower alone ignored", int'(run_status), 11);
    pulse(4'b0101, 4'h0);
    chk("R10 follower with leader", int'(run_status), 15);
    cyc(20);
    pulse(4'h0, 4'b0101);
    chk("R9 stop pair", int'(run_status), 10);
    pulse(4'b0100, 4'h0);
    chk("R10 follower alone leader idle", int'(run_status), 14);
    pulse(4'b0001, 4'h0);
    chk("R10 leader alone", int'(run_status), 15);
    cyc(20);
    pulse(4'b0001, 4'b0001);
    chk("R12 stop beats start", int'(run_status), 14);
    pulse(4'h0, 4'hF);

    // Channel 2 leads channel 3
    set_ch(0, 0, 1, 0, 3);
    set_ch(1, 0, 1, 1, 0);
    set_ch(2, 1, 0, 0, 2);
    set_ch(3, 0, 0, 2, 1);
    pulse(4'hF, 4'h0);
    chk("R5 ch3 follows ch2", int'(cfg_err), 0);
    chk("R5 all running", int'(run_status), 15);
    cyc(20);
    count_irq(3, 24, c);
    chk("R5 ch3 on ch2 enable", c, 12);
    cfg_cks[7:6] = 2'd1;
    @(negedge clk);
    chk("R8 mismatch stops follower", int'(run_status), 7);
    chk("R8 mismatch flagged", int'(cfg_err), 1);
    cfg_cks[7:6] = 2'd0;
    cyc(3);
    chk("R11 flag sticky", int'(cfg_err), 1);
    pulse(4'b1100, 4'h0);
    chk("R10 restart with leader", int'(run_status), 15);
    cyc(30);

    // Leader on enable 2 with a follower
    do_reset();
    set_ch(0, 0, 2, 0, 1);
    set_ch(1, 0, 2, 2, 1);
    pulse(4'b0011, 4'h0);
    chk("R8 grouped on enable 2", int'(run_status), 1);
    chk("R8 enable 2 flagged", int'(cfg_err), 1);
    cyc(20);

    // Odd channel requesting leadership
    do_reset();
    set_ch(1, 1, 0, 0, 2);
    pulse(4'b0010, 4'h0);
    chk("R4 odd leader held", int'(run_status), 0);
    chk("R4 odd leader flagged", int'(cfg_err), 1);

    // Channel 0 leader bit ignored, slave mode rejected
    do_reset();
    set_ch(0, 1, 0, 0, 2);
    pulse(4'b0001, 4'h0);
    chk("R3 ch0 bit ignored run", int'(run_status), 1);
    chk("R3 ch0 bit ignored err", int'(cfg_err), 0);
    cyc(10);
    cfg_mode[1:0] = 2'd2;
    @(negedge clk);
    chk("R3 ch0 slave stopped", int'(run_status), 0);
    chk("R3 ch0 slave flagged", int'(cfg_err), 1);

    // Reserved mode
    do_reset();
    set_ch(2, 0, 0, 3, 5);
    cyc(2);
    chk("R11 reserved mode flagged", int'(cfg_err), 1);
    cyc(5);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      summary();
      $finish;
    end
  end

endmodule